// File: doc/BRIEF.md
# Sample Word Tail-Bit Packer

This block places one converter sample of `SMP_W` data bits and `CTL_W` control bits into a transport word of `WORD_W` bits. It then sends that word out as a stream of octets. The sample goes in the most significant positions and the control bits come right after it. The positions left over at the bottom of the word are filler bits that carry no information. A configuration input chooses what the filler holds. It is either all zeros, or bits from a 9-bit pseudorandom generator that avoid the tones a repeating static pattern would cause.

A receive-side unpacker sits in the same top module. It collects octets back into a word. It knows the filler width from the same parameters as the transmitter, so it simply drops those bits and presents the sample and control fields. Both directions use a valid/ready handshake. A system can wire the octet output to the octet input for loopback, or use each half on its own.

With the default parameters (12-bit sample, 1 control bit, 16-bit word) each word carries three filler bits, and those bits finish the second octet.

Top module: `tailpack_top`

## Requirements
- R1: After reset, `s_ready` and `r_ready` are 1, and `o_valid` and `u_valid` are 0.
- R2: An accepted word is laid out as {sample, control, filler}. The sample sits in bits WORD_W-1 down to WORD_W-SMP_W, the control field sits directly below it, and the filler fills the lowest WORD_W-SMP_W-CTL_W bits. The word leaves as WORD_W/8 octets, most significant octet first, and `o_last` is 1 only on the final octet.
- R3: When `cfg_tail_rand` is 0 at the moment a word is accepted, every filler bit of that word is 0.
- R4: When `cfg_tail_rand` is 1 at acceptance, the filler comes from a 9-bit register. It is seeded with 9'h1FF on reset, and each step computes fb = s[8] ^ s[4] and sets s = {s[7:0], fb}. One step is taken per filler bit. The first fb produced goes into the most significant filler position, and later ones go into lower positions.
- R5: The generator advances only when a word is accepted with `cfg_tail_rand` = 1. Words in zero mode leave the sequence where it was. The mode is sampled at acceptance, so later changes do not affect a word already taken.
- R6: While `o_valid` is 1 and `o_ready` is 0, `o_valid`, `o_data` and `o_last` hold their values.
- R7: After WORD_W/8 octets are accepted on `r_data`, `u_valid` rises and `u_sample`/`u_ctrl` show the sample and control fields of that word. The filler bits have no effect on these outputs.
- R8: While `u_valid` is 1 and `u_ready` is 0, `r_ready` is 0 and `u_sample`/`u_ctrl` hold their values. `u_valid` falls one cycle after it is taken.
- R9: `s_ready` is 0 from the cycle after acceptance until the last octet is taken. It returns to 1 in the cycle right after the transfer of the octet with `o_last` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_tail_rand | input | 1 | Filler mode: 0 zeros, 1 pseudorandom |
| s_valid | input | 1 | Sample offered |
| s_ready | output | 1 | Packer can take a sample |
| s_sample | input | SMP_W | Converter sample |
| s_ctrl | input | CTL_W | Control bits for the sample |
| o_valid | output | 1 | Octet offered |
| o_ready | input | 1 | Octet sink ready |
| o_data | output | 8 | Octet, most significant first |
| o_last | output | 1 | Final octet of a word |
| r_valid | input | 1 | Received octet offered |
| r_ready | output | 1 | Unpacker can take an octet |
| r_data | input | 8 | Received octet |
| u_valid | output | 1 | Unpacked sample available |
| u_ready | input | 1 | Unpacked sample consumer ready |
| u_sample | output | SMP_W | Recovered sample |
| u_ctrl | output | CTL_W | Recovered control bits |

## Verification
A generator that drifts, by stepping when it should not or taking the wrong number of steps, shows up as wrong low bits in the final octet of the next random-mode word. That octet reaches the port two cycles after acceptance. Because the bench keeps its own copy of the sequence, the error persists and is seen on every later random-mode word. A wrong octet index or a bad shift in the serializer corrupts `o_data` or moves `o_last` within the same word. A receive counter that is out of phase puts fields in the wrong bits of `u_sample` at the next `u_valid`. The full sweep of sample values in both filler modes covers every bit position, so a swapped or dropped bit fails on the first word that sets it.

// File: rtl/tailpack_pkg.sv
package tailpack_pkg;

   localparam int OCT_W    = 8;
   localparam int LFSR_W   = 9;
   localparam int TAP_HI   = 8;
   localparam int TAP_LO   = 4;
   localparam logic [LFSR_W-1:0] LFSR_SEED = 9'h1FF;

   // one step of the x^9 + x^5 + 1 sequence; new bit enters at bit 0
   function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
      return {s[LFSR_W-2:0], s[TAP_HI] ^ s[TAP_LO]};
   endfunction

endpackage

// File: rtl/tailpack_lfsr.sv
module tailpack_lfsr
   import tailpack_pkg::*;
#(
   parameter int TAIL_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   output logic [TAIL_W-1:0] tail_bits,
   output logic [LFSR_W-1:0] state_o
);

   logic [LFSR_W-1:0] st_q;
   logic [LFSR_W-1:0] chain [0:TAIL_W];

   assign chain[0] = st_q;

   // unrolled stepping: one step per filler bit, first bit lands highest
   for (genvar g = 0; g < TAIL_W; g++) begin : g_step
      assign chain[g+1]           = lfsr_step(chain[g]);
      assign tail_bits[TAIL_W-1-g] = chain[g+1][0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   st_q <= LFSR_SEED;
      else if (adv) st_q <= chain[TAIL_W];
   end

   assign state_o = st_q;

endmodule

// File: rtl/tailpack_packer.sv
module tailpack_packer
   import tailpack_pkg::*;
#(
   parameter int SMP_W  = 12,
   parameter int CTL_W  = 1,
   parameter int WORD_W = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       s_valid,
   output logic                       s_ready,
   input  logic [SMP_W-1:0]           s_sample,
   input  logic [CTL_W-1:0]           s_ctrl,
   input  logic [WORD_W-SMP_W-CTL_W-1:0] tail_bits,
   output logic                       o_valid,
   input  logic                       o_ready,
   output logic [OCT_W-1:0]           o_data,
   output logic                       o_last
);

   localparam int N_OCT = WORD_W / OCT_W;
   localparam int IDX_W = $clog2(N_OCT);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_OCT - 1);

   logic              busy_q;
   logic [IDX_W-1:0]  idx_q;
   logic [WORD_W-1:0] word_q;

   assign s_ready = !busy_q;
   assign o_valid = busy_q;
   assign o_data  = word_q[WORD_W-1 -: OCT_W];
   assign o_last  = busy_q && (idx_q == LAST_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
         word_q <= '0;
      end else if (!busy_q) begin
         if (s_valid) begin
            word_q <= {s_sample, s_ctrl, tail_bits};
            idx_q  <= '0;
            busy_q <= 1'b1;
         end
      end else if (o_ready) begin
         if (idx_q == LAST_IDX) begin
            busy_q <= 1'b0;
         end else begin
            word_q <= {word_q[WORD_W-OCT_W-1:0], {OCT_W{1'b0}}};
            idx_q  <= idx_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/tailpack_unpacker.sv
module tailpack_unpacker
   import tailpack_pkg::*;
#(
   parameter int SMP_W  = 12,
   parameter int CTL_W  = 1,
   parameter int WORD_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             r_valid,
   output logic             r_ready,
   input  logic [OCT_W-1:0] r_data,
   output logic             u_valid,
   input  logic             u_ready,
   output logic [SMP_W-1:0] u_sample,
   output logic [CTL_W-1:0] u_ctrl
);

   localparam int N_OCT  = WORD_W / OCT_W;
   localparam int IDX_W  = $clog2(N_OCT);
   localparam int TAIL_W = WORD_W - SMP_W - CTL_W;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_OCT - 1);

   logic              full_q;
   logic [IDX_W-1:0]  cnt_q;
   logic [WORD_W-1:0] acc_q;
   logic              unused_tail;

   assign r_ready  = !full_q;
   assign u_valid  = full_q;
   assign u_sample = acc_q[WORD_W-1 -: SMP_W];
   assign u_ctrl   = acc_q[WORD_W-SMP_W-1 -: CTL_W];
   // filler positions are known from configuration and dropped here
   assign unused_tail = ^acc_q[TAIL_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         cnt_q  <= '0;
         acc_q  <= '0;
      end else if (full_q) begin
         if (u_ready) full_q <= 1'b0;
      end else if (r_valid) begin
         acc_q <= {acc_q[WORD_W-OCT_W-1:0], r_data};
         if (cnt_q == LAST_IDX) begin
            cnt_q  <= '0;
            full_q <= 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/tailpack_top.sv
module tailpack_top
   import tailpack_pkg::*;
#(
   parameter int SMP_W        = 12,
   parameter int CTL_W        = 1,
   parameter int WORD_W       = 16,
   parameter bit TAIL_RAND_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_tail_rand,
   input  logic             s_valid,
   output logic             s_ready,
   input  logic [SMP_W-1:0] s_sample,
   input  logic [CTL_W-1:0] s_ctrl,
   output logic             o_valid,
   input  logic             o_ready,
   output logic [7:0]       o_data,
   output logic             o_last,
   input  logic             r_valid,
   output logic             r_ready,
   input  logic [7:0]       r_data,
   output logic             u_valid,
   input  logic             u_ready,
   output logic [SMP_W-1:0] u_sample,
   output logic [CTL_W-1:0] u_ctrl
);

   localparam int TAIL_W = WORD_W - SMP_W - CTL_W;

   if (WORD_W % OCT_W != 0) begin : g_chk_oct
      $error("WORD_W must be a whole number of octets");
   end
   if (WORD_W < 2 * OCT_W) begin : g_chk_min
      $error("WORD_W must span at least two octets");
   end
   if (SMP_W < 1 || CTL_W < 1) begin : g_chk_fields
      $error("SMP_W and CTL_W must each be at least one bit");
   end
   if (TAIL_W < 1) begin : g_chk_tail
      $error("word must leave at least one filler bit");
   end

   logic              accept;
   logic [TAIL_W-1:0] tail_bits;
   logic [LFSR_W-1:0] lfsr_state;

   assign accept = s_valid && s_ready;

   if (TAIL_RAND_EN) begin : g_rand
      logic [TAIL_W-1:0] rand_bits;

      tailpack_lfsr #(.TAIL_W(TAIL_W)) u_lfsr (
         .clk       (clk),
         .rst_n     (rst_n),
         .adv       (accept && cfg_tail_rand),
         .tail_bits (rand_bits),
         .state_o   (lfsr_state)
      );

      assign tail_bits = cfg_tail_rand ? rand_bits : '0;
   end else begin : g_zero
      logic unused_cfg;
      assign unused_cfg = cfg_tail_rand;
      assign tail_bits  = '0;
      assign lfsr_state = LFSR_SEED;
   end

   tailpack_packer #(.SMP_W(SMP_W), .CTL_W(CTL_W), .WORD_W(WORD_W)) u_pack (
      .clk       (clk),
      .rst_n     (rst_n),
      .s_valid   (s_valid),
      .s_ready   (s_ready),
      .s_sample  (s_sample),
      .s_ctrl    (s_ctrl),
      .tail_bits (tail_bits),
      .o_valid   (o_valid),
      .o_ready   (o_ready),
      .o_data    (o_data),
      .o_last    (o_last)
   );

   tailpack_unpacker #(.SMP_W(SMP_W), .CTL_W(CTL_W), .WORD_W(WORD_W)) u_unpack (
      .clk      (clk),
      .rst_n    (rst_n),
      .r_valid  (r_valid),
      .r_ready  (r_ready),
      .r_data   (r_data),
      .u_valid  (u_valid),
      .u_ready  (u_ready),
      .u_sample (u_sample),
      .u_ctrl   (u_ctrl)
   );

endmodule

// File: rtl/tailpack_chk.sv
module tailpack_chk #(
   parameter int SMP_W = 12,
   parameter int CTL_W = 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_tail_rand,
   input logic             s_valid,
   input logic             s_ready,
   input logic             o_valid,
   input logic             o_ready,
   input logic [7:0]       o_data,
   input logic             o_last,
   input logic             u_valid,
   input logic             u_ready,
   input logic [SMP_W-1:0] u_sample,
   input logic [CTL_W-1:0] u_ctrl,
   input logic [8:0]       lfsr_state
);

   // R6: a stalled octet keeps its value
   a_r6_octet_hold: assert property (@(posedge clk) disable iff (!rst_n)
      o_valid && !o_ready |=> o_valid && $stable(o_data) && $stable(o_last));

   // R2: a freshly accepted word starts with a non-final octet
   a_r2_first_octet: assert property (@(posedge clk) disable iff (!rst_n)
      s_valid && s_ready |=> o_valid && !o_last);

   // R9: packer takes a new sample right after the last octet leaves
   a_r9_ready_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      o_valid && o_ready && o_last |=> s_ready);

   // R8: a stalled unpacked sample keeps its value
   a_r8_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
      u_valid && !u_ready |=> u_valid && $stable(u_sample) && $stable(u_ctrl));

   // R5: generator moves only on a random-mode acceptance
   a_r5_lfsr_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !(s_valid && s_ready && cfg_tail_rand) |=> $stable(lfsr_state));

endmodule

bind tailpack_top tailpack_chk #(.SMP_W(SMP_W), .CTL_W(CTL_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cfg_tail_rand (cfg_tail_rand),
   .s_valid       (s_valid),
   .s_ready       (s_ready),
   .o_valid       (o_valid),
   .o_ready       (o_ready),
   .o_data        (o_data),
   .o_last        (o_last),
   .u_valid       (u_valid),
   .u_ready       (u_ready),
   .u_sample      (u_sample),
   .u_ctrl        (u_ctrl),
   .lfsr_state    (lfsr_state)
);

// File: tb/tb_tailpack_top.sv
module tb_tailpack_top;

   localparam int SMP_W  = 12;
   localparam int CTL_W  = 1;
   localparam int WORD_W = 16;
   localparam int TAIL_W = WORD_W - SMP_W - CTL_W;
   localparam int N_OCT  = WORD_W / 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_tail_rand = 1'b0;
   logic             s_valid = 1'b0;
   logic             s_ready;
   logic [SMP_W-1:0] s_sample = '0;
   logic [CTL_W-1:0] s_ctrl = '0;
   logic             o_valid, o_ready, o_last;
   logic [7:0]       o_data;
   logic             r_valid, r_ready;
   logic [7:0]       r_data;
   logic             u_valid;
   logic             u_ready = 1'b1;
   logic [SMP_W-1:0] u_sample;
   logic [CTL_W-1:0] u_ctrl;

   logic       loop = 1'b0;
   logic       tb_o_ready = 1'b0;
   logic       tb_r_valid = 1'b0;
   logic [7:0] tb_r_data = '0;

   assign r_valid = loop ? o_valid : tb_r_valid;
   assign r_data  = loop ? o_data  : tb_r_data;
   assign o_ready = loop ? r_ready : tb_o_ready;

   always #10 clk = ~clk;

   tailpack_top #(.SMP_W(SMP_W), .CTL_W(CTL_W), .WORD_W(WORD_W)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_tail_rand(cfg_tail_rand),
      .s_valid(s_valid), .s_ready(s_ready), .s_sample(s_sample), .s_ctrl(s_ctrl),
      .o_valid(o_valid), .o_ready(o_ready), .o_data(o_data), .o_last(o_last),
      .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data),
      .u_valid(u_valid), .u_ready(u_ready), .u_sample(u_sample), .u_ctrl(u_ctrl)
   );

   int nvec = 0;
   int nbad = 0;
   int cyc  = 0;
   logic [8:0] m_lfsr = 9'h1FF;

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      nvec++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h (t=%0t)", req, act, exp, $time);
      end
   endtask

   // filler model from R3/R4; advances the model only in random mode (R5)
   function automatic logic [TAIL_W-1:0] model_tail(input bit mode);
      logic [TAIL_W-1:0] t;
      logic fb;
      t = '0;
      if (mode) begin
         for (int i = 0; i < TAIL_W; i++) begin
            fb = m_lfsr[8] ^ m_lfsr[4];
            m_lfsr = {m_lfsr[7:0], fb};
            t[TAIL_W-1-i] = fb;
         end
      end
      return t;
   endfunction

   // loopback word: checks every octet (R2/R3/R4) and the unpacked result (R7)
   task automatic loop_word(input logic [SMP_W-1:0] smp, input logic [CTL_W-1:0] ctl,
                            input bit mode);
      logic [WORD_W-1:0] w;
      logic [7:0] eo;
      bit el;
      w = {smp, ctl, model_tail(mode)};
      @(negedge clk);
      cfg_tail_rand = mode;
      s_sample = smp;
      s_ctrl = ctl;
      s_valid = 1'b1;
      chk(s_ready, "R9", 32'(s_ready), 32'd1);
      @(negedge clk);
      s_valid = 1'b0;
      cfg_tail_rand = ~mode;   // R5: mode change after acceptance has no effect
      for (int k = 0; k < N_OCT; k++) begin
         eo = w[WORD_W-1-8*k -: 8];
         el = (k == N_OCT-1);
         chk(o_valid && o_data == eo && o_last == el, mode ? "R4" : "R3",
             32'({o_valid, o_last, o_data}), 32'({1'b1, el, eo}));
         @(negedge clk);
      end
      chk(u_valid && u_sample == smp && u_ctrl == ctl, "R7",
          32'({u_valid, u_sample, u_ctrl}), 32'({1'b1, smp, ctl}));
   endtask

   // receive-only word with explicit filler (R7)
   task automatic rx_word(input logic [WORD_W-1:0] w);
      for (int k = 0; k < N_OCT; k++) begin
         @(negedge clk);
         tb_r_valid = 1'b1;
         tb_r_data = w[WORD_W-1-8*k -: 8];
      end
      @(negedge clk);
      tb_r_valid = 1'b0;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         nbad++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   end

   initial begin
      logic [WORD_W-1:0] w;
      logic [SMP_W-1:0] hs;
      logic [CTL_W-1:0] hc;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(s_ready && r_ready && !o_valid && !u_valid, "R1",
          32'({s_ready, r_ready, o_valid, u_valid}), 32'b1100);

      // R6/R9: stalled octet output, random mode word
      loop = 1'b0;
      tb_o_ready = 1'b0;
      w = {12'hA5C, 1'b1, model_tail(1'b1)};
      cfg_tail_rand = 1'b1;
      s_sample = 12'hA5C;
      s_ctrl = 1'b1;
      s_valid = 1'b1;
      @(negedge clk);
      s_valid = 1'b0;
      cfg_tail_rand = 1'b0;
      for (int i = 0; i < 3; i++) begin
         chk(o_valid && o_data == w[15:8] && !o_last, "R6",
             32'({o_valid, o_last, o_data}), 32'({1'b1, 1'b0, w[15:8]}));
         chk(!s_ready, "R9", 32'(s_ready), 32'd0);
         @(negedge clk);
      end
      tb_o_ready = 1'b1;
      @(negedge clk);
      chk(o_valid && o_data == w[7:0] && o_last, "R4",
          32'({o_valid, o_last, o_data}), 32'({1'b1, 1'b1, w[7:0]}));
      chk(!s_ready, "R9", 32'(s_ready), 32'd0);
      @(negedge clk);
      chk(!o_valid && s_ready, "R9", 32'({o_valid, s_ready}), 32'b01);
      tb_o_ready = 1'b0;

      // R7: filler content does not reach the unpacked outputs
      u_ready = 1'b0;
      for (int t = 0; t < (1 << TAIL_W); t++) begin
         rx_word({12'h3C9, 1'b0, TAIL_W'(t)});
         chk(u_valid && u_sample == 12'h3C9 && u_ctrl == 1'b0, "R7",
             32'({u_valid, u_sample, u_ctrl}), 32'({1'b1, 12'h3C9, 1'b0}));
         if (t == 5) begin
            // R8: held sample blocks further octets
            hs = u_sample;
            hc = u_ctrl;
            tb_r_valid = 1'b1;
            tb_r_data = 8'hFF;
            for (int i = 0; i < 3; i++) begin
               @(negedge clk);
               chk(!r_ready && u_valid && u_sample == hs && u_ctrl == hc, "R8",
                   32'({r_ready, u_valid, u_sample, u_ctrl}), 32'({1'b0, 1'b1, hs, hc}));
            end
            tb_r_valid = 1'b0;
         end
         u_ready = 1'b1;
         @(negedge clk);
         chk(!u_valid && r_ready, "R8", 32'({u_valid, r_ready}), 32'b01);
         u_ready = 1'b0;
      end
      u_ready = 1'b1;

      // loopback sweeps: random, zero (both control values), random again (R5)
      loop = 1'b1;
      for (int i = 0; i < 256; i++)
         loop_word(SMP_W'(i * 37 + 11), CTL_W'(i), 1'b1);
      for (int c = 0; c < 2; c++)
         for (int i = 0; i < (1 << SMP_W); i++)
            loop_word(SMP_W'(i), CTL_W'(c), 1'b0);
      for (int i = 0; i < (1 << SMP_W); i++)
         loop_word(SMP_W'(i), CTL_W'(i >> 3), 1'b1);

      @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

endmodule